// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the per-channel modem status register of a serial port. Four modem handshake inputs arrive as active-low pins: carrier detect, ring indicator, data-set-ready and clear-to-send. Each pin passes through a two-flop synchronizer and is inverted. The result is an active-high level nibble in the upper half of an 8-bit status byte. The lower half holds four sticky change flags, which tell software that a line moved since the last time the byte was read.

When internal loopback is enabled, the four levels come from the low nibble of the modem control register rather than from the pins, and the nibble is crossed over. A read strobe clears all four change flags. A change in the same cycle as the read is kept. An interrupt request is raised while a flag is set and modem-status interrupts are enabled.

Top module: `modem_status_reg`

## Requirements
- R1: Outside loopback, status bits 7, 6, 5 and 4 are the inverse of the carrier, ring, set-ready and clear-to-send pins. A pin change appears there two clock edges after it is sampled.
- R2: In loopback, bit 7 = ctl_i[3], bit 6 = ctl_i[2], bit 5 = ctl_i[0], bit 4 = ctl_i[1], and the pins have no effect on the status byte.
- R3: Status bits 3, 1 and 0 are set when the level in bit 7, bit 5 or bit 4, respectively, changes in either direction.
- R4: Status bit 2 is set only when the ring level in bit 6 falls from 1 to 0. In normal mode that is the pin going from low to high; in loopback it is ctl_i[2] going from 1 to 0. A rise of bit 6 sets no flag.
- R5: A change flag stays set until a read. Only a change event sets it.
- R6: A clock edge with rd_i high clears all four change flags.
- R7: A change event at the same edge as a read leaves its own flag set, while the other flags clear.
- R8: Entering or leaving loopback sets no change flag, even when the levels differ between the two sources.
- R9: irq_o is high exactly while irq_en_i is high and any of status bits 3..0 is set. It drops after a read with no coincident event.
- R10: Synchronous reset (rst_n low) clears all flags and loads the current levels as the reference, so the lines present at reset raise no flag after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_n_i | input | 1 | Carrier detect pin, active low |
| ring_n_i | input | 1 | Ring indicator pin, active low |
| set_ready_n_i | input | 1 | Data-set-ready pin, active low |
| clear_send_n_i | input | 1 | Clear-to-send pin, active low |
| loop_en_i | input | 1 | Internal loopback enable |
| ctl_i | input | 4 | Modem control register bits 3..0 |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| rd_i | input | 1 | Read strobe for the status byte |
| status_o | output | 8 | Levels in bits 7..4, change flags in bits 3..0 |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A read that clears the flags and a line change that sets one can fall in the same clock edge. The bench provokes this in loopback. At the negative edge it changes a control bit and raises the read strobe together, with a different flag already pending. Both then take effect at the next rising edge. The bench then expects the new flag to survive and the old one to be gone. An assertion checks the same rule at every edge: each event present at a read edge must appear in the flags afterwards.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int NLINES = 4;

  // Bit order matches status bits 7..4: carrier, ring, set-ready, clear-send
  typedef struct packed {
    logic cd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;

  // Choose the level source: control bits are crossed over in loopback
  function automatic mline_t pick_src(input logic loop, input mline_t pin_act,
                                      input logic [3:0] ctl);
    mline_t r;
    if (loop) begin
      r.cd  = ctl[3];
      r.ri  = ctl[2];
      r.dsr = ctl[0];
      r.cts = ctl[1];
    end else begin
      r = pin_act;
    end
    return r;
  endfunction

  // Change events: any toggle, except ring which only flags a 1->0 fall
  function automatic logic [NLINES-1:0] change_evt(input mline_t cur, input mline_t prev);
    mline_t e;
    e.cd  = cur.cd ^ prev.cd;
    e.ri  = prev.ri & ~cur.ri;
    e.dsr = cur.dsr ^ prev.dsr;
    e.cts = cur.cts ^ prev.cts;
    return e;
  endfunction
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d_i;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) stg[s] <= stg[s-1];
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mstat_track.sv
module mstat_track
  import mstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en_i,
  input  mline_t            cur_i,
  input  logic              rd_i,
  output logic [NLINES-1:0] flags_o,
  output logic [NLINES-1:0] evt_o,
  output logic              loop_sw_o
);
  mline_t            prev_q;
  logic              loop_q;
  logic [NLINES-1:0] flags_q;

  assign loop_sw_o = loop_en_i ^ loop_q;
  assign evt_o     = loop_sw_o ? '0 : change_evt(cur_i, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= cur_i;
      loop_q  <= loop_en_i;
      flags_q <= '0;
    end else begin
      prev_q  <= cur_i;
      loop_q  <= loop_en_i;
      flags_q <= (flags_q & ~{NLINES{rd_i}}) | evt_o;
    end
  end

  assign flags_o = flags_q;

  // R6: a read with no coincident event leaves no flag
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !(|evt_o)) |=> (flags_q == '0));

  // R7: every event survives the edge it occurs on, read or not
  p_event_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |=> ((flags_q & $past(evt_o)) == $past(evt_o)));

  // R5: a flag only rises because of an event
  p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q) & ~$past(evt_o)) == '0));

  // R8: a loopback switch adds no flag
  p_switch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_sw_o |=> ((flags_q & ~$past(flags_q)) == '0));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import mstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_n_i,
  input  logic       ring_n_i,
  input  logic       set_ready_n_i,
  input  logic       clear_send_n_i,
  input  logic       loop_en_i,
  input  logic [3:0] ctl_i,
  input  logic       irq_en_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic [NLINES-1:0] pins_n, pins_sync, flags, evt;
  logic              loop_sw;
  mline_t            cur;

  assign pins_n = {carrier_n_i, ring_n_i, set_ready_n_i, clear_send_n_i};

  mstat_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (pins_n),
    .q_o (pins_sync)
  );

  assign cur = pick_src(loop_en_i, mline_t'(~pins_sync), ctl_i);

  mstat_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_en_i (loop_en_i),
    .cur_i     (cur),
    .rd_i      (rd_i),
    .flags_o   (flags),
    .evt_o     (evt),
    .loop_sw_o (loop_sw)
  );

  assign status_o = {cur, flags};
  assign irq_o    = irq_en_i & (|flags);

  // R9: the request falls after a read with no coincident event
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !(|evt)) |=> !irq_o);

  // R9: no request without a visible flag
  p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|status_o[3:0]));
endmodule

// File: tb/sim_modem_status_reg.sv
module sim_modem_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'b1111;  // {carrier, ring, set_ready, clear_send}, active low
  logic       loop_en = 1'b0;
  logic [3:0] ctl = 4'h0;
  logic       irq_en = 1'b1;
  logic       rd = 1'b0;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  modem_status_reg u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .carrier_n_i    (pins[3]),
    .ring_n_i       (pins[2]),
    .set_ready_n_i  (pins[1]),
    .clear_send_n_i (pins[0]),
    .loop_en_i      (loop_en),
    .ctl_i          (ctl),
    .irq_en_i       (irq_en),
    .rd_i           (rd),
    .status_o       (status),
    .irq_o          (irq)
  );

  typedef struct packed {
    logic [3:0] pins;
    logic       loop;
    logic [3:0] ctl;
    logic       ien;
    logic       rd;
    logic [7:0] stat;
    logic       irq;
  } vec_t;

  localparam int NVEC = 12;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b0111, 1'b0, 4'b0000, 1'b1, 1'b1, 8'h88, 1'b1},  // R1 R3 carrier on
    {4'b0001, 1'b0, 4'b0000, 1'b1, 1'b1, 8'hE2, 1'b1},  // R3 R4 ring rise silent
    {4'b0100, 1'b0, 4'b0000, 1'b0, 1'b0, 8'hB5, 1'b0},  // R4 ring fall, R9 masked
    {4'b0100, 1'b0, 4'b0000, 1'b1, 1'b1, 8'hB5, 1'b1},  // R5 R9 sticky, enabled
    {4'b0100, 1'b1, 4'b0000, 1'b1, 1'b0, 8'h00, 1'b0},  // R8 enter loopback
    {4'b0100, 1'b1, 4'b1010, 1'b1, 1'b1, 8'h99, 1'b1},  // R2 R3 crossed map
    {4'b0100, 1'b1, 4'b0101, 1'b1, 1'b1, 8'h6B, 1'b1},  // R2 R4 loop ring rise
    {4'b0100, 1'b1, 4'b0001, 1'b1, 1'b1, 8'h24, 1'b1},  // R4 loop ring fall
    {4'b1111, 1'b1, 4'b0001, 1'b1, 1'b0, 8'h20, 1'b0},  // R2 pins ignored
    {4'b1111, 1'b0, 4'b0001, 1'b1, 1'b0, 8'h00, 1'b0},  // R8 leave loopback
    {4'b1011, 1'b0, 4'b0001, 1'b1, 1'b0, 8'h40, 1'b0},  // R1 R4 ring active
    {4'b1111, 1'b0, 4'b0001, 1'b1, 1'b1, 8'h04, 1'b1}   // R4 ring trailing edge
  };

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got status=%h irq=%b, expected status=%h irq=%b",
               tag, got[8:1], got[0], exp[8:1], exp[0]);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got no completion, expected completion");
    finish_run();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    check("R10 reset idle", {status, irq}, {8'h00, 1'b0});

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      pins = v.pins;
      loop_en = v.loop;
      ctl = v.ctl;
      irq_en = v.ien;
      cyc(3);
      check($sformatf("R1 R2 R3 R4 vector %0d", i), {status, irq}, {v.stat, v.irq});
      if (v.rd) begin
        do_read();
        check($sformatf("R6 R9 read after vector %0d", i), {status[3:0], irq}, 5'b0);
      end
    end

    // R10: lines active during reset give levels but no flags
    pins = 4'b0000;
    loop_en = 1'b0;
    rst_n = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    check("R10 reset with active lines", {status, irq}, {8'hF0, 1'b0});

    // R8: enter loopback with differing levels
    loop_en = 1'b1;
    ctl = 4'b0000;
    cyc(3);
    check("R8 switch no flag", {status, irq}, {8'h00, 1'b0});

    ctl = 4'b0010;
    cyc(3);
    check("R3 loop clear-send", {status, irq}, {8'h11, 1'b1});

    // R7: event and read at the same edge
    ctl = 4'b1010;
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
    check("R7 coincident read", {status, irq}, {8'h98, 1'b1});
    do_read();
    check("R6 cleared", {status, irq}, {8'h90, 1'b0});

    // R5: flag holds over many cycles
    ctl = 4'b1000;
    cyc(20);
    check("R5 sticky", {status, irq}, {8'h81, 1'b1});

    // R9: enable gates the request
    irq_en = 1'b0;
    cyc(1);
    check("R9 masked", {status, irq}, {8'h81, 1'b0});
    irq_en = 1'b1;
    cyc(1);
    check("R9 unmasked", {status, irq}, {8'h81, 1'b1});

    finish_run();
  end
endmodule